// File: doc/BRIEF.md
# Requester Outstanding-Transaction Tracker

This block lives at a requesting node of a directory-coherent machine and keeps one table entry per block address that has a coherence request in flight. When the node issues a read, a read-exclusive, an upgrade or a writeback, the tracker records it. It then consumes the replies that come back for that address: data replies carrying an invalidation count, speculative data, negative acknowledgements and owner acknowledgements. It also consumes invalidation acknowledgements from sharers and interventions sent by other nodes. It reports each transaction as complete exactly once, and it decides whether an incoming intervention is forwarded now, parked until a write finishes, or thrown away.

Write completion is a two-sided condition. The reply and the acknowledgements travel on separate paths, so acknowledgements may arrive before the reply that says how many to expect. Each entry keeps a signed balance: an early acknowledgement drives it negative, and the count in the reply brings it back. A refused request is signalled combinationally through a busy flag, so the issuing logic can hold the request and try again. A NACKed request is reissued on a retry port with a priority that grows with every refusal.

Top module: `txn_tracker`

## Requirements
- R1: A read-exclusive (kind 1) or upgrade (kind 2) entry reports completion only after a data reply (reply kind 0) has arrived and the number of invalidation acknowledgements received equals the count carried in that reply, with acknowledgements arriving in any mix of before and after the reply; `doneValid` pulses for one cycle two clock edges after the completing input.
- R2: An intervention whose address matches an outstanding read-exclusive or upgrade entry is not forwarded; it is released with that entry's completion, seen as `doneIvn` = 1.
- R3: An intervention whose address matches an outstanding writeback (kind 3) entry produces a one-cycle `ivnDropValid` and no forward, and is not released at completion (`doneIvn` = 0).
- R4: `reqBusy` is high whenever all entries are in use or `reqAddr` equals the address of an entry still in use; a refused request leaves no entry behind.
- R5: A NACK (reply kind 2) to an entry produces a `retryValid` pulse on the next cycle with that entry's address; an upgrade is retried as kind 1, and any other kind is retried unchanged.
- R6: The retry priority is 1 after the first NACK of a transaction and rises by one with each further NACK, holding at 7; a new transaction on the same address starts again from 1.
- R7: After a speculative reply (kind 1), a later data reply completes the entry with `doneOverride` = 1. An owner acknowledgement (kind 3) completes it with `doneOverride` = 0. Neither a speculative reply on its own nor an owner acknowledgement without a preceding speculative reply completes an entry.
- R8: An intervention that matches no entry, or matches a read (kind 0) entry, is forwarded with `ivnFwdValid` and its address one cycle later.
- R9: Read and writeback entries complete on a data reply carrying a count of 0; when several entries become complete in the same cycle, each is reported once, one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | New request issued this cycle |
| reqAddr | input | ADDR_W | Block address of the new request |
| reqKind | input | 2 | 0 read, 1 read-exclusive, 2 upgrade, 3 writeback |
| reqBusy | output | 1 | Request refused (table full or address already in use) |
| rplValid | input | 1 | Reply present |
| rplAddr | input | ADDR_W | Block address of the reply |
| rplKind | input | 2 | 0 data, 1 speculative data, 2 NACK, 3 owner acknowledgement |
| rplAckCnt | input | CNT_W | Invalidation acknowledgements to expect (data reply) |
| ackValid | input | 1 | Invalidation acknowledgement present |
| ackAddr | input | ADDR_W | Block address of the acknowledgement |
| ivnValid | input | 1 | Incoming intervention present |
| ivnAddr | input | ADDR_W | Block address of the intervention |
| doneValid | output | 1 | One transaction completed |
| doneAddr | output | ADDR_W | Address of the completed transaction |
| doneOverride | output | 1 | Speculative data was replaced by owner data |
| doneIvn | output | 1 | A parked intervention must now be serviced |
| retryValid | output | 1 | Reissue a NACKed request |
| retryAddr | output | ADDR_W | Address to reissue |
| retryKind | output | 2 | Kind to reissue |
| retryPrio | output | PRIO_W | Priority attached to the reissue |
| ivnFwdValid | output | 1 | Intervention to service now |
| ivnFwdAddr | output | ADDR_W | Address of that intervention |
| ivnDropValid | output | 1 | Intervention discarded |

## Verification
The assertions take for granted that replies and acknowledgements arrive only for addresses with an entry in use. They also assume that a reply never reaches an entry that is already complete and that no reply carries more acknowledgements than the count width holds. The stimulus keeps to these: it issues every reply and acknowledgement against a request it opened itself, and sends exactly the promised number of acknowledgements, in sweeps over every split of early and late acknowledgements for counts 0 through 5. Completion is the last event of each transaction, so no acknowledgement can reach a closed entry.

// File: rtl/txn_pkg.sv
package txn_pkg;

  typedef enum logic [1:0] {
    K_READ  = 2'd0,
    K_RDEX  = 2'd1,
    K_UPGR  = 2'd2,
    K_WBACK = 2'd3
  } reqKind_e;

  typedef enum logic [1:0] {
    P_DATA   = 2'd0,
    P_SPEC   = 2'd1,
    P_NACK   = 2'd2,
    P_OWNACK = 2'd3
  } rplKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic allocEn;
    logic rplEn;
    logic ackEn;
    logic holdEn;
    logic passEn;
    logic dropEn;
    logic retireEn;
  } trkStrobe_t;

endpackage

// File: rtl/txn_entry.sv
module txn_entry
  import txn_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 4,
  parameter int PRIO_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              allocEn,
  input  logic              retireEn,
  input  logic              holdEn,
  input  logic              rplEn,
  input  logic              ackEn,
  input  rplKind_e          rplKind,
  input  logic [CNT_W-1:0]  rplCnt,
  input  logic [ADDR_W-1:0] reqAddr,
  input  reqKind_e          reqKind,
  output logic              validQ,
  output logic [ADDR_W-1:0] addrQ,
  output reqKind_e          kindQ,
  output logic [PRIO_W-1:0] prioQ,
  output logic              ovrQ,
  output logic              heldQ,
  output logic              ready
);
  localparam int BAL_W = CNT_W + 1;
  localparam logic [PRIO_W-1:0] PRIO_MAX = {PRIO_W{1'b1}};

  logic gotRplQ, gotSpecQ;
  logic signed [BAL_W-1:0] balQ, addV, subV;

  // early acks push the balance negative; the reply count restores it
  assign addV  = (rplEn && rplKind == P_DATA) ? $signed({1'b0, rplCnt}) : '0;
  assign subV  = ackEn ? $signed(BAL_W'(1)) : '0;
  assign ready = validQ && gotRplQ && (balQ == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ   <= 1'b0;
      addrQ    <= '0;
      kindQ    <= K_READ;
      prioQ    <= '0;
      ovrQ     <= 1'b0;
      heldQ    <= 1'b0;
      gotRplQ  <= 1'b0;
      gotSpecQ <= 1'b0;
      balQ     <= '0;
    end else if (allocEn) begin
      validQ   <= 1'b1;
      addrQ    <= reqAddr;
      kindQ    <= reqKind;
      prioQ    <= '0;
      ovrQ     <= 1'b0;
      heldQ    <= 1'b0;
      gotRplQ  <= 1'b0;
      gotSpecQ <= 1'b0;
      balQ     <= '0;
    end else begin
      if (retireEn) validQ <= 1'b0;
      if (holdEn)   heldQ  <= 1'b1;
      balQ <= balQ + addV - subV;
      if (rplEn) begin
        unique case (rplKind)
          P_DATA: begin
            gotRplQ <= 1'b1;
            ovrQ    <= gotSpecQ;
          end
          P_SPEC:   gotSpecQ <= 1'b1;
          P_OWNACK: if (gotSpecQ) gotRplQ <= 1'b1;
          P_NACK: begin
            if (kindQ == K_UPGR) kindQ <= K_RDEX;
            if (prioQ != PRIO_MAX) prioQ <= prioQ + 1'b1;
            gotSpecQ <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/txn_datapath.sv
module txn_datapath
  import txn_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 8,
  parameter int CNT_W   = 4,
  parameter int PRIO_W  = 3,
  parameter int IDX_W   = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  trkStrobe_t         st,
  input  logic [IDX_W-1:0]   allocIdx,
  input  logic [IDX_W-1:0]   rplIdx,
  input  logic [IDX_W-1:0]   ackIdx,
  input  logic [IDX_W-1:0]   ivnIdx,
  input  logic [IDX_W-1:0]   retireIdx,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [1:0]         reqKind,
  input  logic [ADDR_W-1:0]  rplAddr,
  input  logic [1:0]         rplKind,
  input  logic [CNT_W-1:0]   rplAckCnt,
  input  logic [ADDR_W-1:0]  ackAddr,
  input  logic [ADDR_W-1:0]  ivnAddr,
  output logic [ENTRIES-1:0] validVec,
  output logic [ENTRIES-1:0] readyVec,
  output logic [ENTRIES-1:0] writeVec,
  output logic [ENTRIES-1:0] wbVec,
  output logic [ENTRIES-1:0] reqHitVec,
  output logic [ENTRIES-1:0] rplHitVec,
  output logic [ENTRIES-1:0] ackHitVec,
  output logic [ENTRIES-1:0] ivnHitVec,
  output logic               doneValid,
  output logic [ADDR_W-1:0]  doneAddr,
  output logic               doneOverride,
  output logic               doneIvn,
  output logic               retryValid,
  output logic [ADDR_W-1:0]  retryAddr,
  output logic [1:0]         retryKind,
  output logic [PRIO_W-1:0]  retryPrio,
  output logic               ivnFwdValid,
  output logic [ADDR_W-1:0]  ivnFwdAddr,
  output logic               ivnDropValid
);
  localparam logic [PRIO_W-1:0] PRIO_MAX = {PRIO_W{1'b1}};

  logic [ENTRIES-1:0][ADDR_W-1:0] addrArr;
  logic [ENTRIES-1:0][PRIO_W-1:0] prioArr;
  reqKind_e                       kindArr [ENTRIES];
  logic [ENTRIES-1:0]             ovrVec, heldVec;
  rplKind_e                       rplKindE;

  assign rplKindE = rplKind_e'(rplKind);

  for (genvar i = 0; i < ENTRIES; i++) begin : gEntry
    txn_entry #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PRIO_W(PRIO_W)) entry_i (
      .clk      (clk),
      .rstN     (rstN),
      .allocEn  (st.allocEn  && allocIdx  == IDX_W'(i)),
      .retireEn (st.retireEn && retireIdx == IDX_W'(i)),
      .holdEn   (st.holdEn   && ivnIdx    == IDX_W'(i)),
      .rplEn    (st.rplEn    && rplIdx    == IDX_W'(i)),
      .ackEn    (st.ackEn    && ackIdx    == IDX_W'(i)),
      .rplKind  (rplKindE),
      .rplCnt   (rplAckCnt),
      .reqAddr  (reqAddr),
      .reqKind  (reqKind_e'(reqKind)),
      .validQ   (validVec[i]),
      .addrQ    (addrArr[i]),
      .kindQ    (kindArr[i]),
      .prioQ    (prioArr[i]),
      .ovrQ     (ovrVec[i]),
      .heldQ    (heldVec[i]),
      .ready    (readyVec[i])
    );
    // address compare front end
    assign reqHitVec[i] = validVec[i] && addrArr[i] == reqAddr;
    assign rplHitVec[i] = validVec[i] && addrArr[i] == rplAddr;
    assign ackHitVec[i] = validVec[i] && addrArr[i] == ackAddr;
    assign ivnHitVec[i] = validVec[i] && addrArr[i] == ivnAddr;
    assign writeVec[i]  = validVec[i] && (kindArr[i] == K_RDEX || kindArr[i] == K_UPGR);
    assign wbVec[i]     = validVec[i] && kindArr[i] == K_WBACK;
  end

  logic     nackNow;
  reqKind_e nackKind;
  assign nackNow  = st.rplEn && rplKindE == P_NACK;
  assign nackKind = (kindArr[rplIdx] == K_UPGR) ? K_RDEX : kindArr[rplIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneValid    <= 1'b0;
      doneAddr     <= '0;
      doneOverride <= 1'b0;
      doneIvn      <= 1'b0;
      retryValid   <= 1'b0;
      retryAddr    <= '0;
      retryKind    <= '0;
      retryPrio    <= '0;
      ivnFwdValid  <= 1'b0;
      ivnFwdAddr   <= '0;
      ivnDropValid <= 1'b0;
    end else begin
      doneValid    <= st.retireEn;
      ivnFwdValid  <= st.passEn;
      ivnDropValid <= st.dropEn;
      retryValid   <= nackNow;
      if (st.retireEn) begin
        doneAddr     <= addrArr[retireIdx];
        doneOverride <= ovrVec[retireIdx];
        doneIvn      <= heldVec[retireIdx];
      end
      if (st.passEn) ivnFwdAddr <= ivnAddr;
      if (nackNow) begin
        retryAddr <= addrArr[rplIdx];
        retryKind <= nackKind;
        retryPrio <= (prioArr[rplIdx] == PRIO_MAX) ? PRIO_MAX : prioArr[rplIdx] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/txn_control.sv
module txn_control
  import txn_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int IDX_W   = 2
) (
  input  logic               reqValid,
  input  logic               rplValid,
  input  logic               ackValid,
  input  logic               ivnValid,
  input  logic [ENTRIES-1:0] validVec,
  input  logic [ENTRIES-1:0] readyVec,
  input  logic [ENTRIES-1:0] writeVec,
  input  logic [ENTRIES-1:0] wbVec,
  input  logic [ENTRIES-1:0] reqHitVec,
  input  logic [ENTRIES-1:0] rplHitVec,
  input  logic [ENTRIES-1:0] ackHitVec,
  input  logic [ENTRIES-1:0] ivnHitVec,
  output trkStrobe_t         st,
  output logic [IDX_W-1:0]   allocIdx,
  output logic [IDX_W-1:0]   rplIdx,
  output logic [IDX_W-1:0]   ackIdx,
  output logic [IDX_W-1:0]   ivnIdx,
  output logic [IDX_W-1:0]   retireIdx,
  output logic               reqBusy
);
  logic tableFull, retiringHit, ivnOnWrite, ivnOnWb;

  // lowest-index encoders (free slot, hit slots, ready slot)
  always_comb begin
    allocIdx  = '0;
    rplIdx    = '0;
    ackIdx    = '0;
    ivnIdx    = '0;
    retireIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!validVec[i]) allocIdx  = IDX_W'(i);
      if (rplHitVec[i]) rplIdx    = IDX_W'(i);
      if (ackHitVec[i]) ackIdx    = IDX_W'(i);
      if (ivnHitVec[i]) ivnIdx    = IDX_W'(i);
      if (readyVec[i])  retireIdx = IDX_W'(i);
    end
  end

  assign tableFull   = &validVec;
  assign reqBusy     = tableFull || (|reqHitVec);
  assign ivnOnWrite  = |(ivnHitVec & writeVec);
  assign ivnOnWb     = |(ivnHitVec & wbVec);
  // an intervention on an entry that closes this cycle is serviced at once
  assign retiringHit = st.retireEn && ivnHitVec[retireIdx];

  always_comb begin
    st          = '0;
    st.allocEn  = reqValid && !reqBusy;
    st.rplEn    = rplValid && (|rplHitVec);
    st.ackEn    = ackValid && (|ackHitVec);
    st.retireEn = |readyVec;
    st.dropEn   = ivnValid && ivnOnWb;
    st.holdEn   = ivnValid && ivnOnWrite && !retiringHit;
    st.passEn   = ivnValid && !ivnOnWb && !(ivnOnWrite && !retiringHit);
  end
endmodule

// File: rtl/txn_tracker.sv
module txn_tracker
  import txn_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 8,
  parameter int CNT_W   = 4,
  parameter int PRIO_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqKind,
  output logic              reqBusy,
  input  logic              rplValid,
  input  logic [ADDR_W-1:0] rplAddr,
  input  logic [1:0]        rplKind,
  input  logic [CNT_W-1:0]  rplAckCnt,
  input  logic              ackValid,
  input  logic [ADDR_W-1:0] ackAddr,
  input  logic              ivnValid,
  input  logic [ADDR_W-1:0] ivnAddr,
  output logic              doneValid,
  output logic [ADDR_W-1:0] doneAddr,
  output logic              doneOverride,
  output logic              doneIvn,
  output logic              retryValid,
  output logic [ADDR_W-1:0] retryAddr,
  output logic [1:0]        retryKind,
  output logic [PRIO_W-1:0] retryPrio,
  output logic              ivnFwdValid,
  output logic [ADDR_W-1:0] ivnFwdAddr,
  output logic              ivnDropValid
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  trkStrobe_t         st;
  logic [IDX_W-1:0]   allocIdx, rplIdx, ackIdx, ivnIdx, retireIdx;
  logic [ENTRIES-1:0] validVec, readyVec, writeVec, wbVec;
  logic [ENTRIES-1:0] reqHitVec, rplHitVec, ackHitVec, ivnHitVec;

  txn_control #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) ctrl_i (
    .reqValid  (reqValid),
    .rplValid  (rplValid),
    .ackValid  (ackValid),
    .ivnValid  (ivnValid),
    .validVec  (validVec),
    .readyVec  (readyVec),
    .writeVec  (writeVec),
    .wbVec     (wbVec),
    .reqHitVec (reqHitVec),
    .rplHitVec (rplHitVec),
    .ackHitVec (ackHitVec),
    .ivnHitVec (ivnHitVec),
    .st        (st),
    .allocIdx  (allocIdx),
    .rplIdx    (rplIdx),
    .ackIdx    (ackIdx),
    .ivnIdx    (ivnIdx),
    .retireIdx (retireIdx),
    .reqBusy   (reqBusy)
  );

  txn_datapath #(
    .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PRIO_W(PRIO_W), .IDX_W(IDX_W)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .st           (st),
    .allocIdx     (allocIdx),
    .rplIdx       (rplIdx),
    .ackIdx       (ackIdx),
    .ivnIdx       (ivnIdx),
    .retireIdx    (retireIdx),
    .reqAddr      (reqAddr),
    .reqKind      (reqKind),
    .rplAddr      (rplAddr),
    .rplKind      (rplKind),
    .rplAckCnt    (rplAckCnt),
    .ackAddr      (ackAddr),
    .ivnAddr      (ivnAddr),
    .validVec     (validVec),
    .readyVec     (readyVec),
    .writeVec     (writeVec),
    .wbVec        (wbVec),
    .reqHitVec    (reqHitVec),
    .rplHitVec    (rplHitVec),
    .ackHitVec    (ackHitVec),
    .ivnHitVec    (ivnHitVec),
    .doneValid    (doneValid),
    .doneAddr     (doneAddr),
    .doneOverride (doneOverride),
    .doneIvn      (doneIvn),
    .retryValid   (retryValid),
    .retryAddr    (retryAddr),
    .retryKind    (retryKind),
    .retryPrio    (retryPrio),
    .ivnFwdValid  (ivnFwdValid),
    .ivnFwdAddr   (ivnFwdAddr),
    .ivnDropValid (ivnDropValid)
  );
endmodule

// File: rtl/txn_tracker_chk.sv
module txn_tracker_chk #(
  parameter int ENTRIES = 4,
  parameter int PRIO_W  = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               reqBusy,
  input logic [ENTRIES-1:0] validVec,
  input logic [ENTRIES-1:0] readyVec,
  input logic [ENTRIES-1:0] rplHitVec,
  input logic               rplValid,
  input logic [1:0]         rplKind,
  input logic               retryValid,
  input logic [1:0]         retryKind,
  input logic [PRIO_W-1:0]  retryPrio,
  input logic               doneValid,
  input logic               ivnFwdValid,
  input logic               ivnDropValid
);
  assert_full_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    (&validVec) |-> reqBusy);

  assert_nack_retry_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rplValid && rplKind == 2'd2 && (|rplHitVec)) |=> retryValid);

  assert_no_upgrade_retry_R5: assert property (@(posedge clk) disable iff (!rstN)
    retryValid |-> retryKind != 2'd2);

  assert_prio_raised_R6: assert property (@(posedge clk) disable iff (!rstN)
    retryValid |-> retryPrio != '0);

  assert_drop_not_fwd_R3: assert property (@(posedge clk) disable iff (!rstN)
    ivnDropValid |-> !ivnFwdValid);

  assert_done_after_ready_R1: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> $past(|readyVec));

  assert_ready_drains_R9: assert property (@(posedge clk) disable iff (!rstN)
    (|readyVec) |=> doneValid);
endmodule

bind txn_tracker txn_tracker_chk #(.ENTRIES(ENTRIES), .PRIO_W(PRIO_W)) chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .reqBusy      (reqBusy),
  .validVec     (validVec),
  .readyVec     (readyVec),
  .rplHitVec    (rplHitVec),
  .rplValid     (rplValid),
  .rplKind      (rplKind),
  .retryValid   (retryValid),
  .retryKind    (retryKind),
  .retryPrio    (retryPrio),
  .doneValid    (doneValid),
  .ivnFwdValid  (ivnFwdValid),
  .ivnDropValid (ivnDropValid)
);

// File: tb/txn_tracker_tb_top.sv
`timescale 1ns/1ps
module txn_tracker_tb_top;
  localparam int ADDR_W = 8;
  localparam int CNT_W  = 4;
  localparam int PRIO_W = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 0, rplValid = 0, ackValid = 0, ivnValid = 0;
  logic [ADDR_W-1:0] reqAddr = '0, rplAddr = '0, ackAddr = '0, ivnAddr = '0;
  logic [1:0] reqKind = '0, rplKind = '0;
  logic [CNT_W-1:0] rplAckCnt = '0;
  logic reqBusy, doneValid, doneOverride, doneIvn, retryValid, ivnFwdValid, ivnDropValid;
  logic [ADDR_W-1:0] doneAddr, retryAddr, ivnFwdAddr;
  logic [1:0] retryKind;
  logic [PRIO_W-1:0] retryPrio;

  always #10 clk = ~clk;

  txn_tracker #(.ENTRIES(4), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PRIO_W(PRIO_W)) dut_i (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqAddr(reqAddr), .reqKind(reqKind), .reqBusy(reqBusy),
    .rplValid(rplValid), .rplAddr(rplAddr), .rplKind(rplKind), .rplAckCnt(rplAckCnt),
    .ackValid(ackValid), .ackAddr(ackAddr), .ivnValid(ivnValid), .ivnAddr(ivnAddr),
    .doneValid(doneValid), .doneAddr(doneAddr), .doneOverride(doneOverride), .doneIvn(doneIvn),
    .retryValid(retryValid), .retryAddr(retryAddr), .retryKind(retryKind), .retryPrio(retryPrio),
    .ivnFwdValid(ivnFwdValid), .ivnFwdAddr(ivnFwdAddr), .ivnDropValid(ivnDropValid)
  );

  int total = 0, bad = 0;
  int doneCnt = 0, retryCnt = 0, fwdCnt = 0, dropCnt = 0;
  int lastDoneAddr, lastDoneOvr, lastDoneIvn, lastRetryAddr, lastRetryKind, lastRetryPrio, lastFwdAddr;

  // output pulses are one cycle wide and stable at the falling edge
  always @(negedge clk) begin
    if (rstN) begin
      if (doneValid) begin
        doneCnt++; lastDoneAddr = doneAddr; lastDoneOvr = doneOverride; lastDoneIvn = doneIvn;
      end
      if (retryValid) begin
        retryCnt++; lastRetryAddr = retryAddr; lastRetryKind = retryKind; lastRetryPrio = retryPrio;
      end
      if (ivnFwdValid) begin fwdCnt++; lastFwdAddr = ivnFwdAddr; end
      if (ivnDropValid) dropCnt++;
    end
  end

  task automatic check(string rq, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic doReq(int kind, int addr);
    reqValid = 1; reqKind = 2'(kind); reqAddr = ADDR_W'(addr);
    tick(); reqValid = 0;
  endtask

  task automatic doRpl(int kind, int addr, int cnt);
    rplValid = 1; rplKind = 2'(kind); rplAddr = ADDR_W'(addr); rplAckCnt = CNT_W'(cnt);
    tick(); rplValid = 0;
  endtask

  task automatic doAck(int addr);
    ackValid = 1; ackAddr = ADDR_W'(addr);
    tick(); ackValid = 0;
  endtask

  task automatic doIvn(int addr);
    ivnValid = 1; ivnAddr = ADDR_W'(addr);
    tick(); ivnValid = 0;
  endtask

  function automatic int probeBusy(int addr);
    reqAddr = ADDR_W'(addr);
    return 0;
  endfunction

  initial begin : watchdog
    #(20 * 100000);
    bad++; total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int base, b2, busyNow, dummy;
    tick(3);
    // reset state
    check("R4", "busy after reset", int'(reqBusy), 0);
    check("R9", "done after reset", int'(doneValid), 0);
    check("R5", "retry after reset", int'(retryValid), 0);
    rstN = 1'b1;
    tick(2);

    // R1: every split of early/late acks for counts 0..5
    for (int cnt = 0; cnt <= 5; cnt++) begin
      for (int pre = 0; pre <= cnt; pre++) begin
        int a, kind;
        a = 8'h40 + cnt * 8 + pre;
        kind = (pre % 2 == 0) ? 1 : 2;
        base = doneCnt;
        doReq(kind, a);
        for (int e = 0; e <= cnt; e++) begin
          if (e == cnt) begin
            tick(3);
            check("R1", "no close before last event", doneCnt, base);
          end
          if (e < pre) doAck(a);
          else if (e == pre) doRpl(0, a, cnt);
          else doAck(a);
        end
        tick(3);
        check("R1", "closed once", doneCnt, base + 1);
        check("R1", "closed address", lastDoneAddr, a);
      end
    end

    // R2: intervention parked behind a write awaiting acks
    base = doneCnt; b2 = fwdCnt;
    doReq(1, 8'h21); doRpl(0, 8'h21, 2); doIvn(8'h21); tick(3);
    check("R2", "no forward while write open", fwdCnt, b2);
    check("R2", "not closed early", doneCnt, base);
    doAck(8'h21); doAck(8'h21); tick(3);
    check("R2", "closed", doneCnt, base + 1);
    check("R2", "parked intervention released", lastDoneIvn, 1);
    // R8: no entry now -> forwarded
    doIvn(8'h21); tick(2);
    check("R8", "forward count unmatched", fwdCnt, b2 + 1);
    check("R8", "forward address", lastFwdAddr, 8'h21);

    // R3: intervention on writeback dropped
    base = doneCnt; b2 = fwdCnt;
    doReq(3, 8'h22); doIvn(8'h22); tick(2);
    check("R3", "drop pulse", dropCnt, 1);
    check("R3", "not forwarded", fwdCnt, b2);
    doRpl(0, 8'h22, 0); tick(3);
    check("R9", "writeback closes", doneCnt, base + 1);
    check("R3", "not released at close", lastDoneIvn, 0);

    // R8: intervention on an open read is forwarded
    b2 = fwdCnt;
    doReq(0, 8'h23); doIvn(8'h23); tick(2);
    check("R8", "forward on read entry", fwdCnt, b2 + 1);
    base = doneCnt;
    doRpl(0, 8'h23, 0); tick(3);
    check("R9", "read closes", doneCnt, base + 1);
    check("R8", "read close has no parked ivn", lastDoneIvn, 0);

    // R5/R6: upgrade NACKed repeatedly
    doReq(2, 8'h24);
    for (int n = 1; n <= 9; n++) begin
      base = retryCnt;
      doRpl(2, 8'h24, 0); tick(1);
      check("R5", "retry pulse", retryCnt, base + 1);
      check("R5", "upgrade retried as read-exclusive", lastRetryKind, 1);
      check("R5", "retry address", lastRetryAddr, 8'h24);
      check("R6", "retry priority", lastRetryPrio, (n < 7) ? n : 7);
    end
    base = doneCnt;
    doRpl(0, 8'h24, 0); tick(3);
    check("R9", "closed after nacks", doneCnt, base + 1);
    doReq(0, 8'h24); doRpl(2, 8'h24, 0); tick(1);
    check("R5", "read retried as read", lastRetryKind, 0);
    check("R6", "priority restarts", lastRetryPrio, 1);
    doRpl(0, 8'h24, 0); tick(3);
    doReq(3, 8'h25); doRpl(2, 8'h25, 0); tick(1);
    check("R5", "writeback retried as writeback", lastRetryKind, 3);
    doRpl(0, 8'h25, 0); tick(3);

    // R7: speculative data override and confirm
    base = doneCnt;
    doReq(0, 8'h26); doRpl(1, 8'h26, 0); tick(3);
    check("R7", "spec alone does not close", doneCnt, base);
    doRpl(0, 8'h26, 0); tick(3);
    check("R7", "owner data closes", doneCnt, base + 1);
    check("R7", "override flagged", lastDoneOvr, 1);
    doReq(0, 8'h27); doRpl(1, 8'h27, 0); doRpl(3, 8'h27, 0); tick(3);
    check("R7", "owner ack closes", doneCnt, base + 2);
    check("R7", "spec confirmed", lastDoneOvr, 0);
    doReq(0, 8'h28); doRpl(3, 8'h28, 0); tick(3);
    check("R7", "owner ack w/o spec ignored", doneCnt, base + 2);
    doRpl(0, 8'h28, 0); tick(3);
    check("R7", "plain data no override", lastDoneOvr, 0);

    // R4: busy on match and on full
    doReq(0, 8'h10); doReq(0, 8'h11); doReq(0, 8'h12);
    reqValid = 1; reqKind = 0; dummy = probeBusy(8'h11); #1; busyNow = int'(reqBusy);
    check("R4", "busy on matching address", busyNow, 1);
    tick(); reqValid = 0;
    doReq(0, 8'h13);
    reqValid = 1; dummy = probeBusy(8'h30); #1; busyNow = int'(reqBusy);
    check("R4", "busy when full", busyNow, 1);
    tick(); reqValid = 0;
    doRpl(0, 8'h10, 0); tick(3);
    reqValid = 1; dummy = probeBusy(8'h30); #1; busyNow = int'(reqBusy);
    check("R4", "refused request left no entry", busyNow, 0);
    tick(); reqValid = 0;
    // R9: two entries complete in the same cycle
    base = doneCnt;
    rplValid = 1; rplKind = 0; rplAddr = 8'h11; rplAckCnt = 0;
    reqValid = 0;
    tick();
    rplAddr = 8'h12; rplValid = 1;
    tick();
    rplAddr = 8'h13;
    tick(); rplValid = 0;
    tick(4);
    check("R9", "three closes reported", doneCnt, base + 3);
    base = doneCnt;
    doReq(1, 8'h50); doRpl(0, 8'h50, 1); doReq(0, 8'h51);
    rplValid = 1; rplKind = 0; rplAddr = 8'h51; rplAckCnt = 0;
    ackValid = 1; ackAddr = 8'h50;
    tick(); rplValid = 0; ackValid = 0;
    tick(4);
    check("R9", "simultaneous ready both reported", doneCnt, base + 2);
    doRpl(0, 8'h30, 0); tick(3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule